// File: doc/BRIEF.md
# Orthogonal Rotated-Lattice Space Vector Solver

This block is the geometric core of a multilevel space vector modulator. It receives the two components of the voltage reference, already scaled and expressed in an orthogonal frame that is turned by 45 degrees against the usual stationary frame. In that frame every switching vector of the converter sits on an integer lattice point. The block finds the unit square of the lattice that contains the reference, and then the half of that square (a right triangle) that holds it. It returns the three dwell times of the triangle's corner vectors and the phase level triple that each corner vector stands for.

The angle is never folded into a sector. The dwell times come from additions and subtractions of the fractional parts of the inputs, with no multiplier. The phase levels come from a sign rule on the corner coordinates. Inputs are signed fixed-point values with `FRAC` fractional bits, and one modulation period `ts` is the integer `2**FRAC` (4096 by default). One register stage sits between the input and the outputs. Sine generation upstream and gate timing downstream belong to other blocks.

Top module: `svp_rot_solver`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and all dwell and state outputs are 0.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, including back-to-back inputs.
- R3: The base corner is (floor(`in_alpha`), floor(`in_beta`)) and fa, fb are the fractional parts in units of 1/4096. `out_upper` is 1 when fa + fb > 4096 and 0 otherwise, so equality counts as lower.
- R4: In the lower triangle, slot 0 holds the base corner with dwell 4096 − fa − fb. Slot 1 holds (base+1, base) with dwell fa. Slot 2 holds (base, base+1) with dwell fb.
- R5: In the upper triangle, slot 0 holds the corner (base+1, base+1) with dwell fa + fb − 4096. Slot 1 holds (base+1, base) with dwell 4096 − fb. Slot 2 holds (base, base+1) with dwell 4096 − fa.
- R6: For every valid output, the three dwell times add up to exactly 4096, and none exceeds 4096.
- R7: A corner (x, y) with k = max(|x|,|y|) maps to the levels (A,B,C) = (0, y, −x) when x ≤ 0 and y ≥ 0, and to (k, k+y, k−x) otherwise. It is packed as A in bits [LW-1:0], B in [2LW-1:LW] and C in [3LW-1:2LW] (LW = 2 by default).
- R8: Any phase level that R7 puts above LEVELS−1 (2 by default) is output as LEVELS−1.
- R9: In a cycle with `in_valid` low, the dwell, state and `out_upper` outputs keep their values, whatever the inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Reference sample strobe |
| in_alpha | input | W | First rotated-frame component, signed, FRAC fractional bits |
| in_beta | input | W | Second rotated-frame component, signed, FRAC fractional bits |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_upper | output | 1 | 1 when the reference lies in the upper triangle |
| out_dwell0 | output | FRAC+1 | Dwell of slot 0 vector |
| out_dwell1 | output | FRAC+1 | Dwell of slot 1 vector |
| out_dwell2 | output | FRAC+1 | Dwell of slot 2 vector |
| out_state0 | output | 3*LW | Level triple of slot 0 vector |
| out_state1 | output | 3*LW | Level triple of slot 1 vector |
| out_state2 | output | 3*LW | Level triple of slot 2 vector |

## Verification
The references are placed in squares of all four sign quadrants, with one sample in each triangle of a square, so that a swapped triangle formula or a mixed-up corner shows up as a wrong dwell or a wrong slot. Two points sit on and just past the diagonal fa + fb = 4096. They separate a strict comparison from a non-strict one. Corners with a negative x and a non-negative y exercise the first branch of the state rule, and corners in the other quadrants exercise the second. A point deep in the third quadrant drives levels past the top and exposes a missing clamp. Back-to-back strobes and idle cycles with changing inputs check the valid timing and the hold behaviour.

// File: rtl/svp_rot_pkg.sv
package svp_rot_pkg;
   typedef enum logic {TRI_LOWER = 1'b0, TRI_UPPER = 1'b1} tri_half_e;

   localparam int NUM_SLOTS = 3;

   function automatic int lvl_width(input int levels);
      return (levels > 2) ? $clog2(levels) : 1;
   endfunction
endpackage

// File: rtl/svp_lattice_locate.sv
module svp_lattice_locate
   import svp_rot_pkg::*;
#(
   parameter int W    = 16,
   parameter int FRAC = 12,
   localparam int IW  = W - FRAC
)(
   input  logic signed [W-1:0]  ref_a,
   input  logic signed [W-1:0]  ref_b,
   output logic signed [IW-1:0] base_a,
   output logic signed [IW-1:0] base_b,
   output logic [FRAC-1:0]      frac_a,
   output logic [FRAC-1:0]      frac_b,
   output tri_half_e            half
);
   localparam logic [FRAC:0] ONE = (FRAC+1)'(2**FRAC);

   logic [FRAC:0] frac_sum;

   // two's complement floor: the integer field is the upper bits
   assign base_a   = ref_a[W-1:FRAC];
   assign base_b   = ref_b[W-1:FRAC];
   assign frac_a   = ref_a[FRAC-1:0];
   assign frac_b   = ref_b[FRAC-1:0];
   assign frac_sum = {1'b0, frac_a} + {1'b0, frac_b};
   assign half     = (frac_sum > ONE) ? TRI_UPPER : TRI_LOWER;
endmodule

// File: rtl/svp_dwell_calc.sv
module svp_dwell_calc
   import svp_rot_pkg::*;
#(
   parameter int FRAC = 12
)(
   input  logic [FRAC-1:0] frac_a,
   input  logic [FRAC-1:0] frac_b,
   input  tri_half_e       half,
   output logic [FRAC:0]   dwell0,
   output logic [FRAC:0]   dwell1,
   output logic [FRAC:0]   dwell2
);
   localparam int DW = FRAC + 3;
   localparam logic signed [DW-1:0] ONE_S = DW'(2**FRAC);

   logic signed [DW-1:0] fa_s, fb_s, raw0, raw1, raw2;

   function automatic logic [FRAC:0] clip(input logic signed [DW-1:0] v);
      if (v < 0)          return '0;
      else if (v > ONE_S) return ONE_S[FRAC:0];
      else                return v[FRAC:0];
   endfunction

   assign fa_s = $signed({3'b000, frac_a});
   assign fb_s = $signed({3'b000, frac_b});

   always_comb begin
      if (half == TRI_UPPER) begin
         raw0 = fa_s + fb_s - ONE_S;   // far corner
         raw1 = ONE_S - fb_s;
         raw2 = ONE_S - fa_s;
      end else begin
         raw0 = ONE_S - fa_s - fb_s;   // base corner
         raw1 = fa_s;
         raw2 = fb_s;
      end
   end

   assign dwell0 = clip(raw0);
   assign dwell1 = clip(raw1);
   assign dwell2 = clip(raw2);
endmodule

// File: rtl/svp_state_map.sv
module svp_state_map #(
   parameter int CW     = 8,
   parameter int LEVELS = 3,
   parameter int LW     = 2
)(
   input  logic signed [CW-1:0] x,
   input  logic signed [CW-1:0] y,
   output logic [3*LW-1:0]      state
);
   localparam logic signed [CW-1:0] TOP = CW'(LEVELS - 1);

   logic signed [CW-1:0] ax, ay, k, lv_a, lv_b, lv_c;

   function automatic logic [LW-1:0] cap(input logic signed [CW-1:0] v);
      if (v < 0)        return '0;
      else if (v > TOP) return TOP[LW-1:0];
      else              return v[LW-1:0];
   endfunction

   always_comb begin
      ax = (x < 0) ? -x : x;
      ay = (y < 0) ? -y : y;
      k  = (ax > ay) ? ax : ay;
      if (x <= 0 && y >= 0) begin
         lv_a = '0;
         lv_b = y;
         lv_c = -x;
      end else begin
         lv_a = k;
         lv_b = k + y;
         lv_c = k - x;
      end
   end

   assign state = {cap(lv_c), cap(lv_b), cap(lv_a)};
endmodule

// File: rtl/svp_rot_solver.sv
module svp_rot_solver
   import svp_rot_pkg::*;
#(
   parameter int W      = 16,
   parameter int FRAC   = 12,
   parameter int LEVELS = 3,
   localparam int LW    = lvl_width(LEVELS)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_alpha,
   input  logic signed [W-1:0] in_beta,
   output logic                out_valid,
   output logic                out_upper,
   output logic [FRAC:0]       out_dwell0,
   output logic [FRAC:0]       out_dwell1,
   output logic [FRAC:0]       out_dwell2,
   output logic [3*LW-1:0]     out_state0,
   output logic [3*LW-1:0]     out_state1,
   output logic [3*LW-1:0]     out_state2
);
   localparam int IW = W - FRAC;
   localparam int CW = IW + 3;

   if (FRAC < 2) begin : g_bad_frac
      $error("svp_rot_solver: FRAC must be at least 2");
   end
   if (IW < 2) begin : g_bad_width
      $error("svp_rot_solver: W must leave at least 2 integer bits");
   end
   if (LEVELS < 2) begin : g_bad_levels
      $error("svp_rot_solver: LEVELS must be at least 2");
   end

   logic signed [IW-1:0] base_a, base_b;
   logic [FRAC-1:0]      frac_a, frac_b;
   tri_half_e            half;
   logic [FRAC:0]        dw0, dw1, dw2;

   svp_lattice_locate #(.W(W), .FRAC(FRAC)) u_locate (
      .ref_a(in_alpha), .ref_b(in_beta),
      .base_a(base_a), .base_b(base_b),
      .frac_a(frac_a), .frac_b(frac_b),
      .half(half)
   );

   svp_dwell_calc #(.FRAC(FRAC)) u_dwell (
      .frac_a(frac_a), .frac_b(frac_b), .half(half),
      .dwell0(dw0), .dwell1(dw1), .dwell2(dw2)
   );

   // corner coordinates per slot, widened so the +1 never wraps
   logic signed [CW-1:0] bx, by, bx1, by1;
   logic signed [CW-1:0] cx [NUM_SLOTS];
   logic signed [CW-1:0] cy [NUM_SLOTS];
   logic [3*LW-1:0]      st [NUM_SLOTS];

   assign bx  = {{3{base_a[IW-1]}}, base_a};
   assign by  = {{3{base_b[IW-1]}}, base_b};
   assign bx1 = bx + CW'(1);
   assign by1 = by + CW'(1);

   always_comb begin
      cx[0] = (half == TRI_UPPER) ? bx1 : bx;
      cy[0] = (half == TRI_UPPER) ? by1 : by;
      cx[1] = bx1;
      cy[1] = by;
      cx[2] = bx;
      cy[2] = by1;
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      svp_state_map #(.CW(CW), .LEVELS(LEVELS), .LW(LW)) u_map (
         .x(cx[s]), .y(cy[s]), .state(st[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_upper  <= 1'b0;
         out_dwell0 <= '0;
         out_dwell1 <= '0;
         out_dwell2 <= '0;
         out_state0 <= '0;
         out_state1 <= '0;
         out_state2 <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_upper  <= (half == TRI_UPPER);
            out_dwell0 <= dw0;
            out_dwell1 <= dw1;
            out_dwell2 <= dw2;
            out_state0 <= st[0];
            out_state1 <= st[1];
            out_state2 <= st[2];
         end
      end
   end
endmodule

// File: rtl/svp_rot_solver_chk.sv
module svp_rot_solver_chk #(
   parameter int FRAC   = 12,
   parameter int LEVELS = 3,
   parameter int LW     = 2
)(
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            out_valid,
   input logic            out_upper,
   input logic [FRAC:0]   out_dwell0,
   input logic [FRAC:0]   out_dwell1,
   input logic [FRAC:0]   out_dwell2,
   input logic [3*LW-1:0] out_state0,
   input logic [3*LW-1:0] out_state1,
   input logic [3*LW-1:0] out_state2
);
   localparam logic [FRAC+1:0] TS = (FRAC+2)'(2**FRAC);

   logic [FRAC+1:0] dwell_sum;
   logic            levels_ok;

   assign dwell_sum = {1'b0, out_dwell0} + {1'b0, out_dwell1} + {1'b0, out_dwell2};

   always_comb begin
      levels_ok = 1'b1;
      for (int p = 0; p < 3; p++) begin
         if (int'(out_state0[p*LW +: LW]) > LEVELS - 1) levels_ok = 1'b0;
         if (int'(out_state1[p*LW +: LW]) > LEVELS - 1) levels_ok = 1'b0;
         if (int'(out_state2[p*LW +: LW]) > LEVELS - 1) levels_ok = 1'b0;
      end
   end

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_dwell_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> dwell_sum == TS);
   assert_dwell_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({1'b0, out_dwell0} <= TS && {1'b0, out_dwell1} <= TS
                     && {1'b0, out_dwell2} <= TS));
   assert_far_corner_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_upper) |-> out_dwell0 != '0);
   assert_level_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      levels_ok);
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_dwell0) && $stable(out_dwell1) && $stable(out_dwell2)
                     && $stable(out_state0) && $stable(out_state1) && $stable(out_state2)
                     && $stable(out_upper)));
endmodule

bind svp_rot_solver svp_rot_solver_chk #(.FRAC(FRAC), .LEVELS(LEVELS), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .out_upper(out_upper), .out_dwell0(out_dwell0), .out_dwell1(out_dwell1),
   .out_dwell2(out_dwell2), .out_state0(out_state0), .out_state1(out_state1),
   .out_state2(out_state2)
);

// File: tb/tb_svp_rot_solver.sv
`timescale 1ns/1ps
module tb_svp_rot_solver;
   localparam int W = 16, FRAC = 12, LEVELS = 3, LW = 2;
   localparam int NV = 9;
   // columns: alpha, beta, upper, d0, d1, d2, s0 A B C, s1 A B C, s2 A B C
   localparam int TV [NV][15] = '{
      '{     0,     0, 0, 4096,    0,    0, 0,0,0, 1,1,0, 0,1,0},
      '{  2048,  2048, 0,    0, 2048, 2048, 0,0,0, 1,1,0, 0,1,0},
      '{ -7168,  2048, 0, 1024, 1024, 2048, 0,0,2, 0,0,1, 0,1,2},
      '{ -5120,  2048, 1, 1024, 2048, 1024, 0,1,1, 0,0,1, 0,1,2},
      '{  5120, -6144, 0, 1024, 1024, 2048, 2,0,1, 2,0,0, 1,0,0},
      '{  7168, -5120, 1, 2048, 1024, 1024, 2,1,0, 2,0,0, 1,0,0},
      '{ -2048, -1024, 1, 1024, 1024, 2048, 0,0,0, 1,0,1, 0,0,1},
      '{ -6144, -6144, 0,    0, 2048, 2048, 2,0,2, 2,0,2, 2,1,2},
      '{  2048,  2049, 1,    1, 2047, 2048, 1,2,0, 1,1,0, 0,1,0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_alpha = '0, in_beta = '0;
   logic out_valid, out_upper;
   logic [FRAC:0] out_dwell0, out_dwell1, out_dwell2;
   logic [3*LW-1:0] out_state0, out_state1, out_state2;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   svp_rot_solver #(.W(W), .FRAC(FRAC), .LEVELS(LEVELS)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_alpha(in_alpha), .in_beta(in_beta),
      .out_valid(out_valid), .out_upper(out_upper),
      .out_dwell0(out_dwell0), .out_dwell1(out_dwell1), .out_dwell2(out_dwell2),
      .out_state0(out_state0), .out_state1(out_state1), .out_state2(out_state2)
   );

   function automatic logic [3*LW-1:0] pk(input int a, input int b, input int c);
      return {c[LW-1:0], b[LW-1:0], a[LW-1:0]};
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input int a, input int b, input logic v);
      in_alpha = W'(a);
      in_beta  = W'(b);
      in_valid = v;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_row(input int i);
      string rq;
      rq = (TV[i][2] != 0) ? "R5" : "R4";
      check("R3", $sformatf("row %0d upper", i), out_upper, TV[i][2]);
      check(rq, $sformatf("row %0d dwells", i),
            {out_dwell0, out_dwell1, out_dwell2},
            {13'(TV[i][3]), 13'(TV[i][4]), 13'(TV[i][5])});
      check(i == 7 ? "R8" : "R7", $sformatf("row %0d states", i),
            {out_state0, out_state1, out_state2},
            {pk(TV[i][6], TV[i][7], TV[i][8]), pk(TV[i][9], TV[i][10], TV[i][11]),
             pk(TV[i][12], TV[i][13], TV[i][14])});
      check("R6", $sformatf("row %0d dwell sum", i),
            out_dwell0 + out_dwell1 + out_dwell2, 4096);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1", "reset valid", out_valid, 0);
      check("R1", "reset outputs", {out_upper, out_dwell0, out_dwell1, out_dwell2,
            out_state0, out_state1, out_state2}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, one sample each followed by an idle cycle
      for (int i = 0; i < NV; i++) begin
         drive(TV[i][0], TV[i][1], 1'b1);
         check("R2", $sformatf("row %0d valid", i), out_valid, 1);
         check_row(i);
         drive(0, 0, 1'b0);
      end

      // R9: idle cycles with changing inputs leave outputs untouched (last row is 8)
      drive(-6144, -6144, 1'b0);
      check("R2", "idle valid low", out_valid, 0);
      check("R9", "hold dwells", {out_dwell0, out_dwell1, out_dwell2},
            {13'(1), 13'(2047), 13'(2048)});
      check("R9", "hold state0 and upper", {out_upper, out_state0}, {1'b1, pk(1,2,0)});

      // R2: back-to-back strobes, each output matches its own input
      drive(TV[3][0], TV[3][1], 1'b1);
      check("R2", "burst first valid", out_valid, 1);
      check_row(3);
      drive(TV[4][0], TV[4][1], 1'b1);
      check("R2", "burst second valid", out_valid, 1);
      check_row(4);
      drive(0, 0, 1'b0);
      check("R2", "burst end valid", out_valid, 0);

      // R1: asynchronous reset mid-run clears outputs
      rst_n = 1'b0;
      #1;
      check("R1", "reset again", {out_valid, out_dwell1, out_state0}, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule